// File: doc/BRIEF.md
# Timed-Unlock Supervisor Sleep Guard

This block is one slice of an 8-bit control register. It guards a single flag that asks the power manager to switch off the brown-out supervisor during the next sleep. Software cannot set that flag with an ordinary write. It first writes a pattern with bits 6 and 5 both high, which opens a short unlock window. It must then write bit 6 high with bit 5 low before that window closes. The flag, seen at bit 6, then runs through a fixed life: a delay phase, an active phase, and finally it clears itself.

A sleep request only counts if it arrives during the active phase. In that case the supervisor-off output is latched and held until a wake-up pulse clears it. The other six bits of the register are stored as ordinary read/write bits. Bit 5 reads back as the state of the unlock window.

Top module: `supv_sleep_guard`

## Requirements
- R1: After the asynchronous reset, the register reads 0x00 and `supv_off_o` is 0.
- R2: The register sits at address `CTRL_ADDR` (default 0x55), and reads from any other address return 0x00. Bits 7 and 4..0 take the written value one cycle after any write to that address. Writes to other addresses change nothing.
- R3: Call the cycle of a write with bit 6 = 1 and bit 5 = 1 cycle 0. Bit 5 reads 1 in cycles 1..4 and 0 from cycle 5 on, with no software action. It also drops the cycle after the window is used by an accepted set.
- R4: A write with bit 6 = 1 and bit 5 = 0 is accepted only while bit 5 reads 1, that is in cycles 1..4 after the unlock. Once accepted, bit 6 reads 1 from the next cycle. The same write with no open window leaves bit 6 at 0.
- R5: Take the accepted set write as cycle 0. The flag is active in cycles 4, 5 and 6.
- R6: Bit 6 reads 1 in cycles 1..6 and returns to 0 in cycle 7 by itself. A sleep request in cycle 7 or later does not qualify.
- R7: A sleep request in an active cycle drives `supv_off_o` to 1 from the next cycle. A sleep request in any other cycle leaves it at 0.
- R8: `supv_off_o` holds at 1 until `wake_i` is high in some cycle, and it reads 0 from the next cycle. If wake and a qualifying sleep arrive in the same cycle, wake wins.
- R9: While bit 6 reads 1, writes cannot change it. A write with bit 6 = 0 does not clear it. A set write does not restart its life, and an unused open window stays open.
- R10: An unlock write made while the window is open restarts the four-cycle count from that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Register address for read and write |
| wdata_i | input | 8 | Write data |
| we_i | input | 1 | Write strobe, one write per cycle |
| rdata_o | output | 8 | Read data for `addr_i` (combinational) |
| sleep_req_i | input | 1 | Sleep request pulse |
| wake_i | input | 1 | Wake-up pulse, clears the supervisor-off request |
| supv_off_o | output | 1 | Request to switch off the brown-out supervisor for this sleep |

## Verification
Every write, sleep and wake is registered on one clock edge. Write effects show on `rdata_o` in the following cycle: bit 5 reads 1 one to four cycles after an unlock, and bit 6 reads 1 one to six cycles after an accepted set. A sleep request in cycles 4 to 6 after the set shows on `supv_off_o` one cycle later. The bench drives each cycle's inputs just after a rising edge and compares both outputs with a cycle-counted reference model at the falling edge of the same cycle. The directed checks name the exact cycle offset of each boundary (4 and 5 for the window, 3/4 and 6/7 for the active phase) and sample in that cycle.

// File: rtl/supv_guard_pkg.sv
package supv_guard_pkg;
  localparam int unsigned REG_W      = 8;
  localparam int unsigned GUARD_POS  = 6;
  localparam int unsigned ENABLE_POS = 5;

  typedef enum logic [1:0] {
    WR_NONE   = 2'd0,
    WR_PLAIN  = 2'd1,
    WR_UNLOCK = 2'd2,
    WR_SET    = 2'd3
  } wr_kind_e;

  function automatic wr_kind_e classify_wr(logic hit, logic g, logic e);
    if (!hit)        return WR_NONE;
    else if (g && e) return WR_UNLOCK;
    else if (g)      return WR_SET;
    else             return WR_PLAIN;
  endfunction
endpackage

// File: rtl/sg_unlock_window.sv
module sg_unlock_window #(
  parameter int unsigned WINDOW_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic unlock_i,
  input  logic consume_i,
  output logic open_o
);
  localparam int unsigned CW = $clog2(WINDOW_CYC + 1);

  logic [CW-1:0] left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              left_q <= '0;
    else if (unlock_i)        left_q <= CW'(WINDOW_CYC);
    else if (consume_i)       left_q <= '0;
    else if (left_q != '0)    left_q <= left_q - CW'(1);
  end

  assign open_o = (left_q != '0);
endmodule

// File: rtl/sg_guard_timer.sv
module sg_guard_timer #(
  parameter int unsigned DELAY_CYC  = 3,
  parameter int unsigned ACTIVE_CYC = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic held_o,
  output logic active_o
);
  localparam int unsigned LIFE = DELAY_CYC + ACTIVE_CYC;
  localparam int unsigned LW   = $clog2(LIFE + 1);

  logic [LW-1:0] life_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            life_q <= '0;
    else if (start_i)       life_q <= LW'(LIFE);
    else if (life_q != '0)  life_q <= life_q - LW'(1);
  end

  // last ACTIVE_CYC steps of the countdown form the active phase
  assign held_o   = (life_q != '0);
  assign active_o = held_o && (life_q <= LW'(ACTIVE_CYC));
endmodule

// File: rtl/sg_supv_latch.sv
module sg_supv_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sleep_req_i,
  input  logic qualify_i,
  input  logic wake_i,
  output logic supv_off_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       supv_off_o <= 1'b0;
    else if (wake_i)                   supv_off_o <= 1'b0;
    else if (sleep_req_i && qualify_i) supv_off_o <= 1'b1;
  end
endmodule

// File: rtl/supv_sleep_guard.sv
module supv_sleep_guard
  import supv_guard_pkg::*;
#(
  parameter int unsigned          ADDR_W     = 8,
  parameter logic [ADDR_W-1:0]    CTRL_ADDR  = 8'h55,
  parameter int unsigned          WINDOW_CYC = 4,
  parameter int unsigned          DELAY_CYC  = 3,
  parameter int unsigned          ACTIVE_CYC = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic              we_i,
  output logic [REG_W-1:0]  rdata_o,
  input  logic              sleep_req_i,
  input  logic              wake_i,
  output logic              supv_off_o
);
  logic      hit;
  wr_kind_e  kind;
  logic      open_w, held_w, active_w, accept_w;
  logic [REG_W-1:0] plain_q;
  logic [REG_W-1:0] view;

  assign hit  = (addr_i == CTRL_ADDR);
  assign kind = classify_wr(hit && we_i, wdata_i[GUARD_POS], wdata_i[ENABLE_POS]);
  // set is honoured only with an open window and an idle flag
  assign accept_w = (kind == WR_SET) && open_w && !held_w;

  for (genvar b = 0; b < REG_W; b++) begin : g_bits
    if (b == GUARD_POS || b == ENABLE_POS) begin : g_tied
      assign plain_q[b] = 1'b0;
    end else begin : g_store
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)               plain_q[b] <= 1'b0;
        else if (kind != WR_NONE)  plain_q[b] <= wdata_i[b];
      end
    end
  end

  sg_unlock_window #(.WINDOW_CYC(WINDOW_CYC)) i_window (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .unlock_i  (kind == WR_UNLOCK),
    .consume_i (accept_w),
    .open_o    (open_w)
  );

  sg_guard_timer #(.DELAY_CYC(DELAY_CYC), .ACTIVE_CYC(ACTIVE_CYC)) i_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (accept_w),
    .held_o   (held_w),
    .active_o (active_w)
  );

  sg_supv_latch i_latch (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sleep_req_i (sleep_req_i),
    .qualify_i   (active_w),
    .wake_i      (wake_i),
    .supv_off_o  (supv_off_o)
  );

  always_comb begin
    view             = plain_q;
    view[GUARD_POS]  = held_w;
    view[ENABLE_POS] = open_w;
  end

  assign rdata_o = hit ? view : '0;
endmodule

// File: rtl/sg_checker.sv
module sg_checker #(
  parameter int unsigned       ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR  = 8'h55,
  parameter int unsigned       WINDOW_CYC = 4,
  parameter int unsigned       DELAY_CYC  = 3,
  parameter int unsigned       ACTIVE_CYC = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [1:0]        wd_hi_i,
  input logic              sleep_req_i,
  input logic              wake_i,
  input logic              open_i,
  input logic              held_i,
  input logic              active_i,
  input logic              supv_off_i
);
  localparam int unsigned LIFE = DELAY_CYC + ACTIVE_CYC;
  localparam int unsigned SW   = $clog2(WINDOW_CYC + 2);
  localparam int unsigned RW   = $clog2(LIFE + 2);

  logic          unlock_seen, set_seen;
  logic [SW-1:0] since_q;
  logic [RW-1:0] run_q;

  assign unlock_seen = we_i && (addr_i == CTRL_ADDR) && (wd_hi_i == 2'b11);
  assign set_seen    = we_i && (addr_i == CTRL_ADDR) && (wd_hi_i == 2'b10);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           since_q <= SW'(WINDOW_CYC);
    else if (unlock_seen)                  since_q <= '0;
    else if (since_q < SW'(WINDOW_CYC))    since_q <= since_q + SW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 run_q <= '0;
    else if (!held_i)            run_q <= '0;
    else if (run_q < RW'(LIFE))  run_q <= run_q + RW'(1);
  end

  AST_WINDOW_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    open_i |-> (since_q < SW'(WINDOW_CYC))); // R3
  AST_SET_NEEDS_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(held_i) |-> $past(open_i && set_seen)); // R4
  AST_ACTIVE_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_i |-> (run_q >= RW'(DELAY_CYC)) && (run_q < RW'(LIFE))); // R5
  AST_AUTO_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    held_i |-> (run_q < RW'(LIFE))); // R6
  AST_SUPV_QUALIFIED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(supv_off_i) |-> $past(sleep_req_i && active_i)); // R7
  AST_SUPV_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (supv_off_i && !wake_i) |=> supv_off_i); // R8
  AST_WAKE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_i |=> !supv_off_i); // R8
endmodule

bind supv_sleep_guard sg_checker #(
  .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .WINDOW_CYC(WINDOW_CYC),
  .DELAY_CYC(DELAY_CYC), .ACTIVE_CYC(ACTIVE_CYC)
) i_sg_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .we_i        (we_i),
  .addr_i      (addr_i),
  .wd_hi_i     (wdata_i[6:5]),
  .sleep_req_i (sleep_req_i),
  .wake_i      (wake_i),
  .open_i      (open_w),
  .held_i      (held_w),
  .active_i    (active_w),
  .supv_off_i  (supv_off_o)
);

// File: tb/test_supv_sleep_guard.sv
module test_supv_sleep_guard;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] CTRL = 8'h55;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] addr = CTRL;
  logic [7:0] wdata = 8'h00;
  logic       we = 1'b0;
  logic       sleep_req = 1'b0;
  logic       wake = 1'b0;
  logic [7:0] rdata;
  logic       supv_off;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // reference model state
  int m_arm = 0;
  int m_life = 0;
  int m_supv = 0;
  logic [7:0] m_plain = 8'h00;

  always #(CLK_PERIOD/2) clk = ~clk;

  supv_sleep_guard i_supv_sleep_guard (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .we_i(we),
    .rdata_o(rdata), .sleep_req_i(sleep_req), .wake_i(wake), .supv_off_o(supv_off)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_arm = 0; m_life = 0; m_supv = 0; m_plain = 8'h00;
    end else begin
      bit wr, unl, st, acc, act;
      wr  = we && (addr == CTRL);
      unl = wr && wdata[6] && wdata[5];
      st  = wr && wdata[6] && !wdata[5];
      acc = st && (m_arm > 0) && (m_life == 0);
      act = (m_life >= 1) && (m_life <= 3);
      if (wake) m_supv = 0;
      else if (sleep_req && act) m_supv = 1;
      if (unl) m_arm = 4;
      else if (acc) m_arm = 0;
      else if (m_arm > 0) m_arm = m_arm - 1;
      if (acc) m_life = 6;
      else if (m_life > 0) m_life = m_life - 1;
      if (wr) m_plain = wdata & 8'h9F;
    end
  end

  task automatic chk(input logic [7:0] got, input logic [7:0] exp, input string tag);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%02h expected=%02h", tag, got, exp);
    end
  endtask

  task automatic compare_all();
    logic [7:0] exp_rd;
    exp_rd = m_plain;
    exp_rd[6] = (m_life > 0);
    exp_rd[5] = (m_arm > 0);
    if (addr != CTRL) begin
      chk(rdata, 8'h00, "R2 foreign read");
    end else begin
      chk({7'd0, rdata[6]}, {7'd0, exp_rd[6]}, "R4 bit6");
      chk({7'd0, rdata[5]}, {7'd0, exp_rd[5]}, "R3 bit5");
      chk(rdata & 8'h9F, exp_rd & 8'h9F, "R2 plain bits");
    end
    chk({7'd0, supv_off}, (m_supv != 0) ? 8'd1 : 8'd0, "R7 supv_off");
  endtask

  task automatic step(input logic w, input logic [7:0] a, input logic [7:0] d,
                      input logic s, input logic k);
    @(posedge clk); #1;
    we = w; addr = a; wdata = d; sleep_req = s; wake = k;
    @(negedge clk);
    compare_all();
  endtask

  task automatic wr(input logic [7:0] d);  step(1'b1, CTRL, d, 1'b0, 1'b0); endtask
  task automatic idle();                   step(1'b0, CTRL, 8'h00, 1'b0, 1'b0); endtask
  task automatic idles(input int n);       for (int i = 0; i < n; i++) idle(); endtask
  task automatic slp();                    step(1'b0, CTRL, 8'h00, 1'b1, 1'b0); endtask
  task automatic wk();                     step(1'b0, CTRL, 8'h00, 1'b0, 1'b1); endtask

  initial begin
    int unsigned wd = 0;
    while (!done && wd < 200000) begin
      @(posedge clk); wd++;
    end
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    idle();
    chk(rdata, 8'h00, "R1 reset read");
    chk({7'd0, supv_off}, 8'h00, "R1 reset supv_off");

    // R2 plain bits and decode
    wr(8'h9F); idle(); chk(rdata, 8'h9F, "R2 plain store");
    step(1'b1, 8'h54, 8'hFF, 1'b0, 1'b0); chk(rdata, 8'h00, "R2 other address read");
    idle(); chk(rdata, 8'h9F, "R2 other address write ignored");

    // R4 set with no unlock
    wr(8'h00); wr(8'h40); idle(); chk(rdata, 8'h00, "R4 set without unlock");

    // R3 window closes after four cycles
    wr(8'h60); idles(3); idle(); chk(rdata, 8'h20, "R3 window open cycle 4");
    wr(8'h40); chk(rdata, 8'h00, "R3 window closed cycle 5");
    idle(); chk(rdata, 8'h00, "R4 late set ignored");

    // R4 set in last slot, R7 early sleep, R6 auto clear
    wr(8'h60); idles(3); wr(8'h40);
    idle(); chk(rdata, 8'h40, "R4 accepted, window consumed");
    idle(); slp(); idle(); chk({7'd0, supv_off}, 8'h00, "R7 sleep in delay phase");
    idle(); idle(); chk(rdata, 8'h40, "R6 still set cycle 6");
    idle(); chk(rdata, 8'h00, "R6 self clear cycle 7");

    // R7 qualifying sleep, R8 hold and wake
    wr(8'h60); wr(8'h40); idles(3); slp();
    idle(); chk({7'd0, supv_off}, 8'h01, "R7 sleep in cycle 4");
    idles(5); chk({7'd0, supv_off}, 8'h01, "R8 held");
    wk(); idle(); chk({7'd0, supv_off}, 8'h00, "R8 wake clears");

    // R5 last active cycle
    wr(8'h60); wr(8'h40); idles(5); slp();
    idle(); chk({7'd0, supv_off}, 8'h01, "R5 sleep in cycle 6");
    wk(); idle();

    // R6 sleep too late
    wr(8'h60); wr(8'h40); idles(6); slp();
    idle(); chk({7'd0, supv_off}, 8'h00, "R6 sleep in cycle 7");

    // R8 wake beats sleep
    wr(8'h60); wr(8'h40); idles(3); slp();
    step(1'b0, CTRL, 8'h00, 1'b1, 1'b1);
    idle(); chk({7'd0, supv_off}, 8'h00, "R8 wake priority");
    idles(4);

    // R9 running flag protected
    wr(8'h60); wr(8'h40); idle(); wr(8'h00);
    idle(); chk(rdata, 8'h40, "R9 zero write no clear");
    wr(8'h60); wr(8'h40);
    idle(); chk(rdata, 8'h60, "R9 set during run ignored");
    idle(); chk(rdata, 8'h20, "R9 life not restarted");
    idles(4);

    // R10 re-unlock restarts window
    wr(8'h60); idles(2); wr(8'h60); idles(3); wr(8'h40);
    idle(); chk(rdata, 8'h40, "R10 restarted window");
    idles(8); wk();

    // mixed traffic against the model
    for (int i = 0; i < 3000; i++) begin
      int unsigned r;
      logic [7:0] lo;
      r  = $urandom % 16;
      lo = 8'($urandom) & 8'h9F;
      case (r)
        0, 1, 2: wr(lo | 8'h60);
        3, 4, 5: wr(lo | 8'h40);
        6:       wr(8'($urandom));
        7:       step(1'b1, 8'($urandom), 8'($urandom), 1'b0, 1'b0);
        8, 9:    slp();
        10:      wk();
        11:      step(1'b0, 8'($urandom), 8'h00, 1'b0, 1'b0);
        default: idle();
      endcase
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule